// File: doc/BRIEF.md
# Phase-Synchronizable PWM Time-Base Counter

This block is the time base of a PWM channel. It counts up, down, or up then down against a programmable period. It can be locked to an upstream time base through a chain of sync pulses. Counting advances only on system clock cycles where the time-base enable `tbclk_en` is high, so a slower time-base clock is expressed as a one-cycle enable on the fast system clock.

A sync event is either an external `sync_in` pulse or a software `sw_force` pulse; the two are ORed together. When phase loading is enabled, a sync event places a programmable phase value into the counter. If the phase value is larger than the period, the counter takes the period value instead. In up-down mode, a control bit chooses the count direction that follows the load, whatever the direction was before it.

Every sync event is also sent to `sync_out` one system clock later, whether or not phase loading is enabled. Channels can therefore be daisy-chained behind a master time base, with a fixed one-cycle delay per stage.

Top module: `pwm_timebase_sync`

## Requirements
- R1: After reset the count is 0, `count_down` is 0 (up), `sync_out` is 0, and a sync event that was waiting before reset is discarded. It is not applied at the first enabled edge after reset.
- R2: With `cnt_mode` = 2'b00 (up), each enabled edge adds one to the count. A count at or above `tb_period` goes to 0, and `count_down` is 0.
- R3: With `cnt_mode` = 2'b01 (down), each enabled edge subtracts one from the count. A count of 0 (or a count above `tb_period`) goes to `tb_period`, and `count_down` is 1.
- R4: With `cnt_mode` = 2'b10 (up-down), the counter rises until it reaches `tb_period`, then falls. It falls until it reaches 0, then rises. `count_down` is 1 while falling.
- R5: With `cnt_mode` = 2'b11 (frozen), the count holds on enabled edges that carry no sync load.
- R6: On a cycle with `tbclk_en` low, the count and direction do not change.
- R7: With `phase_load_en` = 1, a sync event loads `tb_phase` into the count. The load happens at the first `tbclk_en` edge at or after the event: it is at that same edge if the event coincides with `tbclk_en`, and otherwise the event is held until then. The load happens once per event.
- R8: A pulse on `sw_force` has the same effect as a pulse on `sync_in`.
- R9: In up-down mode, a sync load sets `count_down` to `sync_dir_down` (1 = down). In up mode and down mode, `sync_dir_down` has no effect and the direction follows the mode.
- R10: With `phase_load_en` = 0, sync events leave the count and direction as normal counting would make them.
- R11: `sync_out` is high in the system clock cycle after a cycle where `sync_in` or `sw_force` is high, and low otherwise. This holds regardless of `phase_load_en`.
- R12: A sync load with `tb_phase` greater than `tb_period` loads `tb_period`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tbclk_en | input | 1 | Time-base clock enable, one system cycle wide |
| cnt_mode | input | 2 | 00 up, 01 down, 10 up-down, 11 frozen |
| tb_period | input | 16 | Period value |
| tb_phase | input | 16 | Phase value loaded on sync |
| phase_load_en | input | 1 | Enables loading of the phase on sync |
| sync_dir_down | input | 1 | Direction after a sync load in up-down mode (1 down) |
| sync_in | input | 1 | Sync pulse from upstream |
| sw_force | input | 1 | Software-forced sync pulse |
| tb_count | output | 16 | Time-base count |
| count_down | output | 1 | Current count direction (1 down) |
| sync_out | output | 1 | Registered sync pulse to downstream |

## Verification
The hardest case to reach is a sync event that arrives on a cycle without `tbclk_en`. It must stay latent until the next enable, be applied exactly once, and be discarded by a reset that comes in between. The stimulus pulses `sync_in` or `sw_force` with the enable held low, and only then issues enabled ticks. A directed case asserts reset between the pulse and the next tick. Another directed case lands the pulse in the same cycle as the enable, to check that the load is not delayed to the following enable.

// File: rtl/tbsync_pkg.sv
package tbsync_pkg;

    typedef enum logic [1:0] {
        MODE_UP     = 2'b00,
        MODE_DOWN   = 2'b01,
        MODE_UPDOWN = 2'b10,
        MODE_HOLD   = 2'b11
    } cnt_mode_e;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } cnt_dir_e;

    // direction taken after a phase load
    function automatic cnt_dir_e dir_after_load(cnt_mode_e m, logic want_down, cnt_dir_e cur);
        cnt_dir_e d;
        case (m)
            MODE_UP:     d = DIR_UP;
            MODE_DOWN:   d = DIR_DOWN;
            MODE_UPDOWN: d = want_down ? DIR_DOWN : DIR_UP;
            default:     d = cur;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/tbsync_capture.sv
module tbsync_capture (
    input  logic clk,
    input  logic rst,
    input  logic tb_en,
    input  logic load_en,
    input  logic ext_sync,
    input  logic force_sync,
    output logic load_req,
    output logic pend_q,
    output logic fwd_q
);
    logic evt;

    assign evt      = ext_sync | force_sync;
    assign load_req = tb_en & load_en & (evt | pend_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            fwd_q  <= 1'b0;
        end else begin
            fwd_q <= evt;
            if (tb_en) begin
                pend_q <= 1'b0;
            end else if (evt) begin
                pend_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/tbsync_phase_load.sv
module tbsync_phase_load
    import tbsync_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] phase,
    input  logic [W-1:0] period,
    input  cnt_mode_e    mode,
    input  logic         want_down,
    input  cnt_dir_e     cur_dir,
    output logic [W-1:0] load_cnt,
    output cnt_dir_e     load_dir
);
    always_comb begin
        load_cnt = (phase > period) ? period : phase;
        load_dir = dir_after_load(mode, want_down, cur_dir);
    end
endmodule

// File: rtl/tbsync_count_step.sv
module tbsync_count_step
    import tbsync_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] cnt,
    input  cnt_dir_e     dir,
    input  logic [W-1:0] period,
    input  cnt_mode_e    mode,
    output logic [W-1:0] nxt_cnt,
    output cnt_dir_e     nxt_dir
);
    localparam logic [W-1:0] ONE  = W'(1);
    localparam logic [W-1:0] ZERO = '0;

    logic at_top;
    logic at_bot;

    assign at_top = (cnt >= period);
    assign at_bot = (cnt == ZERO);

    always_comb begin
        nxt_cnt = cnt;
        nxt_dir = dir;
        case (mode)
            MODE_UP: begin
                nxt_dir = DIR_UP;
                nxt_cnt = at_top ? ZERO : cnt + ONE;
            end
            MODE_DOWN: begin
                nxt_dir = DIR_DOWN;
                nxt_cnt = (at_bot || cnt > period) ? period : cnt - ONE;
            end
            MODE_UPDOWN: begin
                if (dir == DIR_UP) begin
                    if (at_top) begin
                        nxt_dir = DIR_DOWN;
                        nxt_cnt = at_bot ? ZERO : cnt - ONE;
                    end else begin
                        nxt_cnt = cnt + ONE;
                    end
                end else begin
                    if (at_bot) begin
                        nxt_dir = DIR_UP;
                        nxt_cnt = (period == ZERO) ? ZERO : ONE;
                    end else begin
                        nxt_cnt = cnt - ONE;
                    end
                end
            end
            default: begin
                nxt_cnt = cnt;
                nxt_dir = dir;
            end
        endcase
    end
endmodule

// File: rtl/pwm_timebase_sync.sv
module pwm_timebase_sync
    import tbsync_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tbclk_en,
    input  logic [1:0]       cnt_mode,
    input  logic [CNT_W-1:0] tb_period,
    input  logic [CNT_W-1:0] tb_phase,
    input  logic             phase_load_en,
    input  logic             sync_dir_down,
    input  logic             sync_in,
    input  logic             sw_force,
    output logic [CNT_W-1:0] tb_count,
    output logic             count_down,
    output logic             sync_out
);
    cnt_mode_e        mode;
    logic             load_req;
    logic             sync_pending;
    logic [CNT_W-1:0] cnt_q;
    cnt_dir_e         dir_q;
    logic [CNT_W-1:0] step_cnt;
    cnt_dir_e         step_dir;
    logic [CNT_W-1:0] ld_cnt;
    cnt_dir_e         ld_dir;

    assign mode = cnt_mode_e'(cnt_mode);

    tbsync_capture u_capture (
        .clk        (clk),
        .rst        (rst),
        .tb_en      (tbclk_en),
        .load_en    (phase_load_en),
        .ext_sync   (sync_in),
        .force_sync (sw_force),
        .load_req   (load_req),
        .pend_q     (sync_pending),
        .fwd_q      (sync_out)
    );

    tbsync_phase_load #(.W(CNT_W)) u_load (
        .phase     (tb_phase),
        .period    (tb_period),
        .mode      (mode),
        .want_down (sync_dir_down),
        .cur_dir   (dir_q),
        .load_cnt  (ld_cnt),
        .load_dir  (ld_dir)
    );

    tbsync_count_step #(.W(CNT_W)) u_step (
        .cnt     (cnt_q),
        .dir     (dir_q),
        .period  (tb_period),
        .mode    (mode),
        .nxt_cnt (step_cnt),
        .nxt_dir (step_dir)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            dir_q <= DIR_UP;
        end else if (tbclk_en) begin
            if (load_req) begin
                cnt_q <= ld_cnt;
                dir_q <= ld_dir;
            end else begin
                cnt_q <= step_cnt;
                dir_q <= step_dir;
            end
        end
    end

    assign tb_count   = cnt_q;
    assign count_down = (dir_q == DIR_DOWN);
endmodule

// File: rtl/tbsync_checker.sv
module tbsync_checker #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         tbclk_en,
    input logic [1:0]   cnt_mode,
    input logic [W-1:0] tb_period,
    input logic [W-1:0] tb_phase,
    input logic         phase_load_en,
    input logic         sync_dir_down,
    input logic         sync_in,
    input logic         sw_force,
    input logic [W-1:0] tb_count,
    input logic         count_down,
    input logic         sync_out,
    input logic         sync_pending
);
    // R11
    fwd_high_chk: assert property (@(posedge clk) disable iff (rst)
        (sync_in | sw_force) |=> sync_out);
    // R11
    fwd_low_chk: assert property (@(posedge clk) disable iff (rst)
        !(sync_in | sw_force) |=> !sync_out);
    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tbclk_en |=> ($stable(tb_count) && $stable(count_down)));
    // R2
    up_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (tbclk_en && !phase_load_en && cnt_mode == 2'b00 && tb_count >= tb_period)
        |=> tb_count == '0);
    // R3
    down_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (tbclk_en && !phase_load_en && cnt_mode == 2'b01 && tb_count == '0)
        |=> tb_count == $past(tb_period));
    // R5
    frozen_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (tbclk_en && !phase_load_en && cnt_mode == 2'b11) |=> $stable(tb_count));
    // R7
    pend_load_chk: assert property (@(posedge clk) disable iff (rst)
        (tbclk_en && phase_load_en && sync_pending && tb_phase <= tb_period)
        |=> tb_count == $past(tb_phase));
    // R12
    clamp_chk: assert property (@(posedge clk) disable iff (rst)
        (tbclk_en && phase_load_en && (sync_in | sw_force))
        |=> tb_count <= $past(tb_period));
    // R9
    updown_dir_chk: assert property (@(posedge clk) disable iff (rst)
        (tbclk_en && phase_load_en && (sync_in | sw_force) && cnt_mode == 2'b10)
        |=> count_down == $past(sync_dir_down));
endmodule

bind pwm_timebase_sync tbsync_checker #(.W(CNT_W)) u_tbsync_chk (
    .clk           (clk),
    .rst           (rst),
    .tbclk_en      (tbclk_en),
    .cnt_mode      (cnt_mode),
    .tb_period     (tb_period),
    .tb_phase      (tb_phase),
    .phase_load_en (phase_load_en),
    .sync_dir_down (sync_dir_down),
    .sync_in       (sync_in),
    .sw_force      (sw_force),
    .tb_count      (tb_count),
    .count_down    (count_down),
    .sync_out      (sync_out),
    .sync_pending  (sync_pending)
);

// File: tb/test_pwm_timebase_sync.sv
`timescale 1ns/1ps
module test_pwm_timebase_sync;
    logic        clk = 1'b0;
    logic        rst;
    logic        tbclk_en;
    logic [1:0]  cnt_mode;
    logic [15:0] tb_period;
    logic [15:0] tb_phase;
    logic        phase_load_en;
    logic        sync_dir_down;
    logic        sync_in;
    logic        sw_force;
    logic [15:0] tb_count;
    logic        count_down;
    logic        sync_out;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    pwm_timebase_sync i_pwm_timebase_sync (
        .clk(clk), .rst(rst), .tbclk_en(tbclk_en), .cnt_mode(cnt_mode),
        .tb_period(tb_period), .tb_phase(tb_phase), .phase_load_en(phase_load_en),
        .sync_dir_down(sync_dir_down), .sync_in(sync_in), .sw_force(sw_force),
        .tb_count(tb_count), .count_down(count_down), .sync_out(sync_out)
    );

    typedef struct packed {
        logic [1:0]  mode;
        logic [15:0] period;
        logic [15:0] phase;
        logic        pen;
        logic        sdir;
        logic [1:0]  kind;   // 0 none, 1 sync_in, 2 sw_force
        logic [7:0]  n1;
        logic [7:0]  n2;
        logic [15:0] exp_cnt;
        logic        exp_dir;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{2'b00, 16'd5, 16'd2, 1'b1, 1'b1, 2'd1, 8'd3, 8'd2, 16'd4, 1'b0}, // R7 R2
        '{2'b00, 16'd5, 16'd2, 1'b0, 1'b0, 2'd1, 8'd7, 8'd0, 16'd2, 1'b0}, // R10 R2
        '{2'b01, 16'd5, 16'd3, 1'b1, 1'b0, 2'd1, 8'd2, 8'd1, 16'd2, 1'b1}, // R3 R9
        '{2'b10, 16'd4, 16'd1, 1'b1, 1'b0, 2'd1, 8'd6, 8'd2, 16'd3, 1'b0}, // R4 R9
        '{2'b10, 16'd4, 16'd3, 1'b1, 1'b1, 2'd1, 8'd2, 8'd1, 16'd2, 1'b1}, // R9
        '{2'b10, 16'd4, 16'd9, 1'b1, 1'b1, 2'd1, 8'd0, 8'd1, 16'd3, 1'b1}, // R12
        '{2'b00, 16'd4, 16'd9, 1'b1, 1'b0, 2'd1, 8'd1, 8'd1, 16'd0, 1'b0}, // R12
        '{2'b11, 16'd4, 16'd0, 1'b0, 1'b0, 2'd0, 8'd3, 8'd0, 16'd0, 1'b0}, // R5
        '{2'b10, 16'd3, 16'd0, 1'b1, 1'b1, 2'd2, 8'd4, 8'd1, 16'd1, 1'b0}, // R8 R4
        '{2'b00, 16'd5, 16'd1, 1'b0, 1'b0, 2'd2, 8'd2, 8'd1, 16'd4, 1'b0}  // R8 R10
    };
    string vreq [NV] = '{"R7", "R10", "R3", "R4", "R9", "R12", "R12", "R5", "R8", "R10"};

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        tbclk_en = 0; sync_in = 0; sw_force = 0; cnt_mode = 2'b00;
        tb_period = 16'd0; tb_phase = 16'd0; phase_load_en = 0; sync_dir_down = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        idle_inputs();
        rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
    endtask

    task automatic tick();
        @(negedge clk) tbclk_en = 1;
        @(negedge clk) tbclk_en = 0;
    endtask

    task automatic pulse(input logic [1:0] kind);
        @(negedge clk);
        if (kind == 2'd1) sync_in = 1; else sw_force = 1;
        @(negedge clk);
        check("R11 sync_out high", 32'(sync_out), 32'd1);
        sync_in = 0; sw_force = 0;
        @(negedge clk);
        check("R11 sync_out low", 32'(sync_out), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1;
        idle_inputs();
        do_reset();
        // R1 reset state
        check("R1 count", 32'(tb_count), 32'd0);
        check("R1 dir", 32'(count_down), 32'd0);
        check("R1 sync_out", 32'(sync_out), 32'd0);

        for (int i = 0; i < NV; i++) begin
            do_reset();
            cnt_mode = VECS[i].mode; tb_period = VECS[i].period; tb_phase = VECS[i].phase;
            phase_load_en = VECS[i].pen; sync_dir_down = VECS[i].sdir;
            repeat (int'(VECS[i].n1)) tick();
            if (VECS[i].kind != 2'd0) pulse(VECS[i].kind);
            tick();
            repeat (int'(VECS[i].n2)) tick();
            check({vreq[i], " table count"}, 32'(tb_count), 32'(VECS[i].exp_cnt));
            check({vreq[i], " table dir"}, 32'(count_down), 32'(VECS[i].exp_dir));
        end

        // R6: no movement while the enable is low
        do_reset();
        tb_period = 16'd10;
        tick(); tick();
        repeat (5) @(negedge clk);
        check("R6 hold without enable", 32'(tb_count), 32'd2);

        // R7: sync in same cycle as the enable loads at that edge, once
        do_reset();
        tb_period = 16'd10; tb_phase = 16'd7; phase_load_en = 1;
        tick(); tick(); tick();
        @(negedge clk);
        sync_in = 1; tbclk_en = 1;
        @(negedge clk);
        sync_in = 0; tbclk_en = 0;
        check("R7 same-cycle load", 32'(tb_count), 32'd7);
        check("R11 same-cycle forward", 32'(sync_out), 32'd1);
        tick();
        check("R7 single load", 32'(tb_count), 32'd8);

        // R1: a waiting sync is discarded by reset
        do_reset();
        tb_period = 16'd10; tb_phase = 16'd6; phase_load_en = 1;
        pulse(2'd1);
        do_reset();
        tb_period = 16'd10; tb_phase = 16'd6; phase_load_en = 1;
        tick();
        check("R1 pending cleared", 32'(tb_count), 32'd1);

        // R10/R11: forward with loading disabled, up-down direction untouched
        do_reset();
        cnt_mode = 2'b10; tb_period = 16'd3; tb_phase = 16'd0; sync_dir_down = 1;
        tick(); tick();
        pulse(2'd1);
        tick();
        check("R10 updown count", 32'(tb_count), 32'd3);
        check("R10 updown dir", 32'(count_down), 32'd0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule